// File: doc/BRIEF.md
# In-Order Bus Transaction Queue Tracker

This block follows, from one agent's point of view, every transaction that is outstanding on a pipelined split-phase system bus. Each accepted request strobe takes one slot in a circular in-order queue. The slot then moves through a fixed sequence of phases: a one-clock error phase, a snoop phase (memory transactions only), a response phase and, when data must move, a data phase. Snoop results are applied to the oldest transaction still waiting for them. Responses and data completions are applied only to the oldest transaction. The queue depth is taken from `cfg_depth` while reset is held and is ignored after that.

Each slot is a small state machine with five named states: EMPTY, ERROR, SNOOP, RESPONSE and DATA.
- EMPTY goes to ERROR on allocation.
- ERROR always leaves after one clock. It goes to RESPONSE when an error is indicated or the transaction is not a memory access, and to SNOOP otherwise.
- SNOOP goes to RESPONSE when its snoop result arrives.
- RESPONSE goes to DATA when the response calls for a data transfer. It returns to EMPTY (retire) on a fail, deferred or retry response, on an illegal response, or when no data is due.
- DATA goes to EMPTY when the data phase completes.

A hit-modified snoop marks the transaction as an implicit writeback and makes its data phase mandatory. If defer was sampled, the next response must be deferred or retry. Two sticky error flags report protocol misuse: one for unexpected strobes and one for illegal responses.

`MAX_DEPTH` must be a power of two, and at least 2.

Top module: `bus_ioq_tracker`

## Requirements
- R1: While `rst_n` is low, the queue empties and both error flags clear. The effective depth is latched from `cfg_depth`: 0 becomes 1, and values above `MAX_DEPTH` (8) become 8. Changes to `cfg_depth` after reset have no effect.
- R2: An accepted request appears, on the clock after its strobe, as the youngest entry in phase code 1 (error phase), and `occupancy` rises by one. Phase codes are 0 empty, 1 error, 2 snoop, 3 response and 4 data. The phase of the i-th oldest entry is `phase_vec[3*i+2:3*i]`.
- R3: The error phase lasts exactly one clock. If `err_in` is high during it, the entry goes to phase 3, skips the snoop phase and never enters a data phase. Otherwise a memory request (`req_mem`=1) goes to phase 2 and any other request goes to phase 3.
- R4: `snp_valid` applies `snp_hit`, `snp_hitm` and `snp_defer` to the oldest entry in phase 2, which then moves to phase 3. The hit is shown in `hit_vec` by age.
- R5: A hit-modified snoop sets that entry's bit in `iwb_vec` (implicit writeback) and forces a data phase after a data-carrying response.
- R6: `rsp_valid` acts only on the oldest entry, and only when that entry is in phase 3. Codes 1 (fail), 5 (deferred) and 6 (retry) retire the entry. Any other code retires it when no data is due and moves it to phase 4 when data is due (`req_data` or a hit-modified snoop).
- R7: `dat_done` retires the oldest entry when that entry is in phase 4. The younger entries each move up one age position.
- R8: After a sampled defer, only codes 5 and 6 are legal. Any other code sets `resp_err` and still retires the entry.
- R9: A request strobe while `occupancy` equals the effective depth is dropped: `occupancy` is unchanged and `proto_err` is set.
- R10: A request with `req_own`=1 while four own transactions are outstanding is dropped and sets `proto_err`. Non-own requests are still accepted.
- R11: These strobes set `proto_err` and change no entry: `err_in` with no entry in phase 1, `snp_valid` with no entry in phase 2, `rsp_valid` when the oldest entry is not in phase 3, and `dat_done` when the oldest entry is not in phase 4.
- R12: `proto_err` and `resp_err` stay set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset; depth is sampled while low |
| cfg_depth | input | 4 | Requested pipeline depth |
| req_valid | input | 1 | Request strobe |
| req_mem | input | 1 | Request is a memory access (has snoop phase) |
| req_data | input | 1 | Request carries a data transfer |
| req_own | input | 1 | Request issued by this agent |
| err_in | input | 1 | Error indication for the entry in its error phase |
| snp_valid | input | 1 | Snoop result strobe |
| snp_hit | input | 1 | Shared hit |
| snp_hitm | input | 1 | Hit on a modified line |
| snp_defer | input | 1 | Defer sampled |
| rsp_valid | input | 1 | Response strobe |
| rsp_code | input | 3 | Response code |
| dat_done | input | 1 | Data phase completion |
| occupancy | output | 4 | Outstanding entries |
| phase_vec | output | 24 | Phase codes by age, oldest in bits 2:0 |
| hit_vec | output | 8 | Shared-hit flags by age |
| iwb_vec | output | 8 | Implicit-writeback flags by age |
| proto_err | output | 1 | Sticky protocol error |
| resp_err | output | 1 | Sticky illegal response error |

## Verification
The assertions check, on every cycle:
- that occupancy never exceeds the latched depth;
- that own outstanding transactions never exceed four;
- that an error phase never lasts beyond one clock;
- that both error flags stay set once raised, and that a stray response or a strobe at full depth leaves its mark.

Only the bench scenarios can show that work is applied to the right entry. They cover snoop results reaching the oldest waiting entry, whether a response retires an entry or opens a data phase, age positions shifting on retirement, and a defer turning a normal response into an error while the entry still drains. A reference queue model in the bench follows both directed sequences and seeded random traffic.

// File: rtl/bus_ioq_pkg.sv
package bus_ioq_pkg;

    typedef enum logic [2:0] {
        PH_EMPTY = 3'd0,
        PH_ERR   = 3'd1,
        PH_SNOOP = 3'd2,
        PH_RESP  = 3'd3,
        PH_DATA  = 3'd4
    } phase_e;

    localparam logic [2:0] RSP_FAIL  = 3'd1;
    localparam logic [2:0] RSP_DEFER = 3'd5;
    localparam logic [2:0] RSP_RETRY = 3'd6;

    // Codes that end a transaction without a data phase.
    function automatic logic rsp_ends_now(input logic [2:0] code);
        return (code == RSP_FAIL) || (code == RSP_DEFER) || (code == RSP_RETRY);
    endfunction

    // Codes permitted after a defer was sampled.
    function automatic logic rsp_ok_after_defer(input logic [2:0] code);
        return (code == RSP_DEFER) || (code == RSP_RETRY);
    endfunction

endpackage

// File: rtl/ioq_slot.sv
module ioq_slot
    import bus_ioq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alloc,
    input  logic       a_mem,
    input  logic       a_data,
    input  logic       a_own,
    input  logic       err_in,
    input  logic       snp_sel,
    input  logic       snp_hit,
    input  logic       snp_hitm,
    input  logic       snp_defer,
    input  logic       rsp_sel,
    input  logic [2:0] rsp_code,
    input  logic       dat_sel,
    output logic [2:0] phase_o,
    output logic       hit_o,
    output logic       iwb_o,
    output logic       own_o,
    output logic       retire_o,
    output logic       bad_rsp_o
);

    phase_e st_q, st_d;
    logic   mem_q, mem_d, want_q, want_d, own_q, own_d;
    logic   hit_q, hit_d, iwb_q, iwb_d, dfr_q, dfr_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= PH_EMPTY;
            mem_q  <= 1'b0;
            want_q <= 1'b0;
            own_q  <= 1'b0;
            hit_q  <= 1'b0;
            iwb_q  <= 1'b0;
            dfr_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            mem_q  <= mem_d;
            want_q <= want_d;
            own_q  <= own_d;
            hit_q  <= hit_d;
            iwb_q  <= iwb_d;
            dfr_q  <= dfr_d;
        end
    end

    always_comb begin
        st_d      = st_q;
        mem_d     = mem_q;
        want_d    = want_q;
        own_d     = own_q;
        hit_d     = hit_q;
        iwb_d     = iwb_q;
        dfr_d     = dfr_q;
        retire_o  = 1'b0;
        bad_rsp_o = 1'b0;
        unique case (st_q)
            PH_EMPTY: begin
                if (alloc) begin
                    st_d   = PH_ERR;
                    mem_d  = a_mem;
                    want_d = a_data;
                    own_d  = a_own;
                    hit_d  = 1'b0;
                    iwb_d  = 1'b0;
                    dfr_d  = 1'b0;
                end
            end
            PH_ERR: begin
                if (err_in) begin
                    st_d   = PH_RESP;
                    want_d = 1'b0;
                end else begin
                    st_d = mem_q ? PH_SNOOP : PH_RESP;
                end
            end
            PH_SNOOP: begin
                if (snp_sel) begin
                    st_d   = PH_RESP;
                    hit_d  = snp_hit;
                    iwb_d  = snp_hitm;
                    dfr_d  = snp_defer;
                    want_d = want_q | snp_hitm;
                end
            end
            PH_RESP: begin
                if (rsp_sel) begin
                    bad_rsp_o = dfr_q && !rsp_ok_after_defer(rsp_code);
                    if (bad_rsp_o || rsp_ends_now(rsp_code) || !want_q) begin
                        st_d     = PH_EMPTY;
                        retire_o = 1'b1;
                    end else begin
                        st_d = PH_DATA;
                    end
                end
            end
            PH_DATA: begin
                if (dat_sel) begin
                    st_d     = PH_EMPTY;
                    retire_o = 1'b1;
                end
            end
            default: st_d = PH_EMPTY;
        endcase
    end

    assign phase_o = st_q;
    assign hit_o   = hit_q & (st_q != PH_EMPTY);
    assign iwb_o   = iwb_q & (st_q != PH_EMPTY);
    assign own_o   = own_q & (st_q != PH_EMPTY);

    // R3
    err_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == PH_ERR |=> st_q != PH_ERR);

    // R7
    data_after_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_DATA && $past(st_q) != PH_DATA) |-> $past(st_q) == PH_RESP);

endmodule

// File: rtl/ioq_ctrl.sv
module ioq_ctrl
    import bus_ioq_pkg::*;
#(
    parameter int MAX_DEPTH = 8,
    parameter int OWN_MAX   = 4,
    parameter int PTR_W     = 3,
    parameter int CNT_W     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [CNT_W-1:0]              cfg_depth,
    input  logic                          req_valid,
    input  logic                          req_own,
    input  logic                          err_in,
    input  logic                          snp_valid,
    input  logic                          rsp_valid,
    input  logic                          dat_done,
    input  logic [MAX_DEPTH-1:0][2:0]     ph_i,
    input  logic [MAX_DEPTH-1:0]          retire_v,
    input  logic [MAX_DEPTH-1:0]          own_v,
    input  logic [MAX_DEPTH-1:0]          bad_v,
    output logic [PTR_W-1:0]              head_o,
    output logic [CNT_W-1:0]              count_o,
    output logic [MAX_DEPTH-1:0]          alloc_v,
    output logic [MAX_DEPTH-1:0]          snp_sel_v,
    output logic [MAX_DEPTH-1:0]          rsp_sel_v,
    output logic [MAX_DEPTH-1:0]          dat_sel_v,
    output logic                          proto_err,
    output logic                          resp_err
);

    logic [PTR_W-1:0] head_q, tail, snp_idx;
    logic [CNT_W-1:0] count_q, depth_q, own_cnt;
    logic             accept, retire, err_any, snp_found, proto_ev;
    logic             head_in_resp, head_in_data;

    function automatic logic [CNT_W-1:0] clamp_depth(input logic [CNT_W-1:0] c);
        if (c == '0) return CNT_W'(1);
        if (c > CNT_W'(MAX_DEPTH)) return CNT_W'(MAX_DEPTH);
        return c;
    endfunction

    assign own_cnt      = CNT_W'($countones(own_v));
    assign tail         = head_q + count_q[PTR_W-1:0];
    assign accept       = req_valid && (count_q < depth_q) &&
                          !(req_own && own_cnt >= CNT_W'(OWN_MAX));
    assign retire       = |retire_v;
    assign head_in_resp = ph_i[head_q] == PH_RESP;
    assign head_in_data = ph_i[head_q] == PH_DATA;

    always_comb begin
        err_any   = 1'b0;
        snp_found = 1'b0;
        snp_idx   = head_q;
        for (int i = 0; i < MAX_DEPTH; i++) begin
            if (ph_i[i] == PH_ERR) err_any = 1'b1;
            if (!snp_found && ph_i[head_q + PTR_W'(i)] == PH_SNOOP) begin
                snp_found = 1'b1;
                snp_idx   = head_q + PTR_W'(i);
            end
        end
    end

    always_comb begin
        alloc_v   = '0;
        snp_sel_v = '0;
        rsp_sel_v = '0;
        dat_sel_v = '0;
        if (accept)                    alloc_v[tail]     = 1'b1;
        if (snp_valid && snp_found)    snp_sel_v[snp_idx] = 1'b1;
        if (rsp_valid && head_in_resp) rsp_sel_v[head_q]  = 1'b1;
        if (dat_done && head_in_data)  dat_sel_v[head_q]  = 1'b1;
    end

    assign proto_ev = (req_valid && !accept) || (err_in && !err_any) ||
                      (snp_valid && !snp_found) || (rsp_valid && !head_in_resp) ||
                      (dat_done && !head_in_data);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q   <= clamp_depth(cfg_depth);
            head_q    <= '0;
            count_q   <= '0;
            proto_err <= 1'b0;
            resp_err  <= 1'b0;
        end else begin
            if (retire) head_q <= head_q + PTR_W'(1);
            unique case ({accept, retire})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
            proto_err <= proto_err | proto_ev;
            resp_err  <= resp_err | (|bad_v);
        end
    end

    assign head_o  = head_q;
    assign count_o = count_q;

    // R9
    count_within_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= depth_q);

    // R9
    full_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && count_q == depth_q) |=> (count_q <= $past(count_q) && proto_err));

    // R10
    own_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        own_cnt <= CNT_W'(OWN_MAX));

    // R11
    stray_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !head_in_resp) |=> proto_err);

    // R12
    proto_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R12
    resp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |=> resp_err);

endmodule

// File: rtl/bus_ioq_tracker.sv
module bus_ioq_tracker
    import bus_ioq_pkg::*;
#(
    parameter  int MAX_DEPTH = 8,
    parameter  int OWN_MAX   = 4,
    localparam int PTR_W     = $clog2(MAX_DEPTH),
    localparam int CNT_W     = $clog2(MAX_DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CNT_W-1:0]         cfg_depth,
    input  logic                     req_valid,
    input  logic                     req_mem,
    input  logic                     req_data,
    input  logic                     req_own,
    input  logic                     err_in,
    input  logic                     snp_valid,
    input  logic                     snp_hit,
    input  logic                     snp_hitm,
    input  logic                     snp_defer,
    input  logic                     rsp_valid,
    input  logic [2:0]               rsp_code,
    input  logic                     dat_done,
    output logic [CNT_W-1:0]         occupancy,
    output logic [3*MAX_DEPTH-1:0]   phase_vec,
    output logic [MAX_DEPTH-1:0]     hit_vec,
    output logic [MAX_DEPTH-1:0]     iwb_vec,
    output logic                     proto_err,
    output logic                     resp_err
);

    logic [MAX_DEPTH-1:0][2:0] ph_all;
    logic [MAX_DEPTH-1:0]      retire_v, own_v, bad_v, hit_s, iwb_s;
    logic [MAX_DEPTH-1:0]      alloc_v, snp_sel_v, rsp_sel_v, dat_sel_v;
    logic [PTR_W-1:0]          head;

    ioq_ctrl #(
        .MAX_DEPTH(MAX_DEPTH), .OWN_MAX(OWN_MAX), .PTR_W(PTR_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth),
        .req_valid(req_valid), .req_own(req_own), .err_in(err_in),
        .snp_valid(snp_valid), .rsp_valid(rsp_valid), .dat_done(dat_done),
        .ph_i(ph_all), .retire_v(retire_v), .own_v(own_v), .bad_v(bad_v),
        .head_o(head), .count_o(occupancy), .alloc_v(alloc_v),
        .snp_sel_v(snp_sel_v), .rsp_sel_v(rsp_sel_v), .dat_sel_v(dat_sel_v),
        .proto_err(proto_err), .resp_err(resp_err)
    );

    for (genvar k = 0; k < MAX_DEPTH; k++) begin : g_slot
        ioq_slot u_slot (
            .clk(clk), .rst_n(rst_n), .alloc(alloc_v[k]),
            .a_mem(req_mem), .a_data(req_data), .a_own(req_own),
            .err_in(err_in), .snp_sel(snp_sel_v[k]), .snp_hit(snp_hit),
            .snp_hitm(snp_hitm), .snp_defer(snp_defer), .rsp_sel(rsp_sel_v[k]),
            .rsp_code(rsp_code), .dat_sel(dat_sel_v[k]), .phase_o(ph_all[k]),
            .hit_o(hit_s[k]), .iwb_o(iwb_s[k]), .own_o(own_v[k]),
            .retire_o(retire_v[k]), .bad_rsp_o(bad_v[k])
        );
    end

    // Present entries by age: position 0 is the oldest.
    for (genvar i = 0; i < MAX_DEPTH; i++) begin : g_age
        logic [PTR_W-1:0] slot_of_age;
        assign slot_of_age       = head + PTR_W'(i);
        assign phase_vec[3*i +: 3] = ph_all[slot_of_age];
        assign hit_vec[i]        = hit_s[slot_of_age];
        assign iwb_vec[i]        = iwb_s[slot_of_age];
    end

    // R4
    snoop_single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(snp_sel_v | rsp_sel_v | dat_sel_v) <= 3 && $onehot0(snp_sel_v));

endmodule

// File: tb/bus_ioq_tracker_test.sv
`timescale 1ns/1ps
module bus_ioq_tracker_test;

    localparam int MAXD = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_depth = 4'd8;
    logic        req_valid, req_mem, req_data, req_own, err_in;
    logic        snp_valid, snp_hit, snp_hitm, snp_defer, rsp_valid, dat_done;
    logic [2:0]  rsp_code;
    logic [3:0]  occupancy;
    logic [23:0] phase_vec;
    logic [7:0]  hit_vec, iwb_vec;
    logic        proto_err, resp_err;

    int checks = 0;
    int errors = 0;

    int m_ph[MAXD];
    bit m_mem[MAXD], m_want[MAXD], m_own[MAXD], m_hit[MAXD], m_iwb[MAXD], m_dfr[MAXD];
    int m_cnt, m_depth;
    bit m_perr, m_rerr;

    always #4 clk = ~clk;

    bus_ioq_tracker uut (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth),
        .req_valid(req_valid), .req_mem(req_mem), .req_data(req_data), .req_own(req_own),
        .err_in(err_in), .snp_valid(snp_valid), .snp_hit(snp_hit), .snp_hitm(snp_hitm),
        .snp_defer(snp_defer), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .dat_done(dat_done), .occupancy(occupancy), .phase_vec(phase_vec),
        .hit_vec(hit_vec), .iwb_vec(iwb_vec), .proto_err(proto_err), .resp_err(resp_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int clamp_d(input int c);
        if (c == 0) return 1;
        if (c > MAXD) return MAXD;
        return c;
    endfunction

    function automatic bit ends_now(input int c);
        return c == 1 || c == 5 || c == 6;
    endfunction

    task automatic clr_in();
        req_valid = 0; req_mem = 0; req_data = 0; req_own = 0; err_in = 0;
        snp_valid = 0; snp_hit = 0; snp_hitm = 0; snp_defer = 0;
        rsp_valid = 0; rsp_code = 3'd0; dat_done = 0;
    endtask

    // Reference queue, age ordered, advanced by one clock edge.
    task automatic model_step();
        int  st = -1;
        int  h0 = 0;
        int  own = 0;
        bit  err_any = 0;
        bit  accept, retire = 0, bad;
        for (int i = 0; i < m_cnt; i++) begin
            if (m_own[i]) own++;
            if (m_ph[i] == 1) err_any = 1;
            if (st < 0 && m_ph[i] == 2) st = i;
        end
        if (m_cnt > 0) h0 = m_ph[0];
        accept = req_valid && m_cnt < m_depth && !(req_own && own >= 4);
        if ((req_valid && !accept) || (err_in && !err_any) || (snp_valid && st < 0) ||
            (rsp_valid && h0 != 3) || (dat_done && h0 != 4)) m_perr = 1;
        for (int i = 0; i < m_cnt; i++) begin
            if (m_ph[i] == 1) begin
                if (err_in) begin m_ph[i] = 3; m_want[i] = 0; end
                else m_ph[i] = m_mem[i] ? 2 : 3;
            end
        end
        if (snp_valid && st >= 0) begin
            m_hit[st] = snp_hit; m_iwb[st] = snp_hitm; m_dfr[st] = snp_defer;
            m_want[st] = m_want[st] | snp_hitm; m_ph[st] = 3;
        end
        if (rsp_valid && h0 == 3) begin
            bad = m_dfr[0] && !(rsp_code == 5 || rsp_code == 6);
            if (bad) m_rerr = 1;
            if (bad || ends_now(rsp_code) || !m_want[0]) retire = 1;
            else m_ph[0] = 4;
        end
        if (dat_done && h0 == 4) retire = 1;
        if (accept) begin
            m_ph[m_cnt] = 1; m_mem[m_cnt] = req_mem; m_want[m_cnt] = req_data;
            m_own[m_cnt] = req_own; m_hit[m_cnt] = 0; m_iwb[m_cnt] = 0; m_dfr[m_cnt] = 0;
            m_cnt++;
        end
        if (retire) begin
            for (int i = 0; i < MAXD - 1; i++) begin
                m_ph[i] = m_ph[i+1]; m_mem[i] = m_mem[i+1]; m_want[i] = m_want[i+1];
                m_own[i] = m_own[i+1]; m_hit[i] = m_hit[i+1]; m_iwb[i] = m_iwb[i+1];
                m_dfr[i] = m_dfr[i+1];
            end
            m_ph[MAXD-1] = 0;
            m_cnt--;
        end
    endtask

    task automatic compare(input string tag);
        logic [23:0] ep = '0;
        logic [7:0]  eh = '0, ei = '0;
        for (int i = 0; i < m_cnt; i++) begin
            ep[3*i +: 3] = 3'(m_ph[i]);
            eh[i] = m_hit[i];
            ei[i] = m_iwb[i];
        end
        check(occupancy == 4'(m_cnt), tag, "occupancy", occupancy, m_cnt);
        check(phase_vec == ep, tag, "phase_vec", phase_vec, ep);
        check(hit_vec == eh, tag, "hit_vec", hit_vec, eh);
        check(iwb_vec == ei, tag, "iwb_vec", iwb_vec, ei);
        check({proto_err, resp_err} == {m_perr, m_rerr}, tag, "errors",
              {proto_err, resp_err}, {m_perr, m_rerr});
    endtask

    task automatic tick(input string tag);
        model_step();
        @(negedge clk);
        compare(tag);
        clr_in();
    endtask

    task automatic do_reset(input int cfg, input string tag);
        rst_n = 0; cfg_depth = 4'(cfg); clr_in();
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_cnt = 0; m_depth = clamp_d(cfg); m_perr = 0; m_rerr = 0;
        for (int i = 0; i < MAXD; i++) begin
            m_ph[i] = 0; m_mem[i] = 0; m_want[i] = 0; m_own[i] = 0;
            m_hit[i] = 0; m_iwb[i] = 0; m_dfr[i] = 0;
        end
        compare(tag);
    endtask

    task automatic req(input bit mem, input bit dat, input bit own);
        req_valid = 1; req_mem = mem; req_data = dat; req_own = own;
    endtask

    task automatic random_cycle();
        int  st = -1;
        bit  err_any = 0;
        for (int i = 0; i < m_cnt; i++) begin
            if (m_ph[i] == 1) err_any = 1;
            if (st < 0 && m_ph[i] == 2) st = i;
        end
        if ($urandom_range(0, 99) < 40)
            req($urandom_range(0, 9) < 7, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
        err_in    = err_any ? ($urandom_range(0, 7) == 0) : ($urandom_range(0, 299) == 0);
        snp_valid = (st >= 0) ? ($urandom_range(0, 1) == 1) : ($urandom_range(0, 299) == 0);
        snp_hit   = $urandom_range(0, 2) == 0;
        snp_hitm  = $urandom_range(0, 4) == 0;
        snp_defer = $urandom_range(0, 6) == 0;
        rsp_valid = (m_cnt > 0 && m_ph[0] == 3) ? ($urandom_range(0, 1) == 1)
                                                : ($urandom_range(0, 299) == 0);
        if (m_cnt > 0 && m_dfr[0] && $urandom_range(0, 9) < 8)
            rsp_code = $urandom_range(0, 1) ? 3'd5 : 3'd6;
        else
            rsp_code = 3'($urandom_range(0, 7));
        dat_done  = (m_cnt > 0 && m_ph[0] == 4) ? ($urandom_range(0, 1) == 1)
                                                : ($urandom_range(0, 299) == 0);
    endtask

    initial begin
        #(64'd8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clr_in();
        @(negedge clk);

        // R1: zero depth clamps to one; R9: second request dropped
        do_reset(0, "R1");
        req(1, 0, 0); tick("R2");
        check(phase_vec[2:0] == 3'd1, "R2", "youngest phase", phase_vec[2:0], 1);
        req(0, 0, 0); tick("R9");
        check(occupancy == 4'd1 && proto_err, "R9", "full drop", occupancy, 1);

        // R1: oversized depth clamps to eight; later cfg change ignored
        do_reset(15, "R1");
        cfg_depth = 4'd2;
        for (int i = 0; i < 9; i++) begin req(0, 0, 0); tick("R1"); end
        check(occupancy == 4'd8, "R1", "clamped depth", occupancy, 8);

        // Full memory path with modified hit: R3, R4, R5, R6, R7
        do_reset(3, "R1");
        req(1, 0, 0); tick("R2");
        tick("R3");
        check(phase_vec[2:0] == 3'd2, "R3", "to snoop", phase_vec[2:0], 2);
        snp_valid = 1; snp_hit = 1; snp_hitm = 1; tick("R4");
        check(iwb_vec[0] == 1'b1, "R5", "implicit writeback", iwb_vec[0], 1);
        rsp_valid = 1; rsp_code = 3'd4; tick("R6");
        check(phase_vec[2:0] == 3'd4, "R5", "data forced", phase_vec[2:0], 4);
        dat_done = 1; tick("R7");
        check(occupancy == 4'd0, "R7", "retired", occupancy, 0);

        // R3: error skips snoop and data
        req(1, 1, 0); tick("R2");
        err_in = 1; tick("R3");
        check(phase_vec[2:0] == 3'd3, "R3", "error to response", phase_vec[2:0], 3);
        rsp_valid = 1; rsp_code = 3'd3; tick("R3");
        check(occupancy == 4'd0, "R3", "no data phase", occupancy, 0);

        // R8: illegal response after defer still retires
        req(1, 1, 0); tick("R2"); tick("R3");
        snp_valid = 1; snp_defer = 1; tick("R4");
        rsp_valid = 1; rsp_code = 3'd3; tick("R8");
        check(resp_err && occupancy == 4'd0, "R8", "illegal after defer", resp_err, 1);
        tick("R12");
        check(resp_err == 1'b1, "R12", "resp_err sticky", resp_err, 1);

        // R8: legal deferred response raises nothing
        do_reset(3, "R1");
        req(1, 0, 0); tick("R2"); tick("R3");
        snp_valid = 1; snp_defer = 1; tick("R4");
        rsp_valid = 1; rsp_code = 3'd5; tick("R8");
        check(!resp_err && occupancy == 4'd0, "R8", "deferred legal", resp_err, 0);

        // R4: snoop applies to the oldest waiting entry
        req(1, 0, 0); tick("R2");
        req(1, 0, 0); tick("R2");
        snp_valid = 1; snp_hitm = 1; tick("R4");
        check(iwb_vec == 8'b01, "R4", "oldest snooped", iwb_vec, 1);

        // R10: own limit
        do_reset(8, "R1");
        for (int i = 0; i < 5; i++) begin req(0, 0, 1); tick("R10"); end
        check(occupancy == 4'd4 && proto_err, "R10", "own limit", occupancy, 4);
        req(0, 0, 0); tick("R10");
        check(occupancy == 4'd5, "R10", "other accepted", occupancy, 5);

        // R11: stray strobes on empty queue
        do_reset(4, "R1");
        rsp_valid = 1; rsp_code = 3'd2; tick("R11");
        check(proto_err && occupancy == 4'd0, "R11", "stray response", proto_err, 1);
        dat_done = 1; tick("R11");
        snp_valid = 1; tick("R11");
        err_in = 1; tick("R12");

        // Seeded random traffic against the reference queue
        for (int seg = 0; seg < 40; seg++) begin
            do_reset($urandom_range(0, 15), "R1");
            cfg_depth = 4'($urandom_range(0, 15));
            for (int c = 0; c < 400; c++) begin
                random_cycle();
                tick("R6");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule